// File: doc/BRIEF.md
# Edge-Synchronized Dual Pulse Timer

This block stands in for two resistive paddle inputs on a sound chip that samples its potentiometer lines once per measurement cycle. The chip marks the start of each cycle with a falling edge on a sense line. A free-running 16-bit timer is stamped on that edge, and every later event in the cycle is timed from the stamp. The time at which the edge is serviced plays no part.

Each channel has an 8-bit requested delay. A short fixed offset after the stamp, both pads are pulled low. Each pad is then switched high once the stamp plus its own delay has been reached, so the chip sees a clean low-to-high step. A fixed number of clocks after the later of the two rising steps, both pads are released again. A released pad has its enable low and its value high, which models a weak pull-up. The block also reports the distance between successive stamps as the measured cycle length. It flags an overrun when a new edge arrives before the pads have been released.

Top module: `dual_pulse_timer`

## Requirements
- R1: A falling edge on `senseIn` is recognised when `senseIn` is low in a cycle after a cycle in which it was high. That clock edge stamps the timer and starts a new cycle. Rising edges of `senseIn` have no effect on the pads.
- R2: After reset, and whenever the pads are released, `padOe` is all zeros and `padOut` is all ones. `cycleLen` and `overrun` reset to 0.
- R3: Counting the stamping edge as edge 1, both pads are enabled and driven low after clock edge EARLY_OFF+1. Before that edge they stay released.
- R4: Channel i (delay bits [8i+7:8i] of `delayIn`) rises after clock edge max(d_i, EARLY_OFF+1)+1. This is the stamp plus d_i, measured on the same timer. Once high, the pad stays high until it is released.
- R5: A requested delay at or below EARLY_OFF still produces a low phase of at least one clock before that channel rises.
- R6: Both pads are released together after clock edge max(d0, d1, EARLY_OFF+1) + RELEASE_DLY + 1.
- R7: With the defaults, a delay of 255 on either channel releases the pads by clock 264, well inside a 512-clock cycle.
- R8: On every edge after the first, `cycleLen` becomes the current stamp minus the previous stamp, modulo 2^16. It keeps its value between edges and stays 0 until the second edge.
- R9: `delayIn` is sampled only on the stamping edge. A change during a cycle takes effect in the next cycle.
- R10: A falling edge that arrives while the pads are not yet released sets `overrun` to 1, releases the pads on that same edge and starts a new cycle normally. An edge that arrives while the pads are released sets `overrun` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| senseIn | input | 1 | Cycle-start sense line, falling edge active |
| delayIn | input | NCH*DW (16) | Requested delays, channel 0 in the low byte |
| padOut | output | NCH (2) | Pad output value |
| padOe | output | NCH (2) | Pad output enable (0 = released, weak high) |
| cycleLen | output | TW (16) | Last measured cycle length in clocks |
| overrun | output | 1 | Edge arrived before the previous release |

## Verification
The bench builds the block with its defaults: two channels, 8-bit delays, a 16-bit timer, EARLY_OFF of 2 and RELEASE_DLY of 8. With these values the full delay range fits inside cycles of 300 to 700 clocks. This covers the low-phase floor for delays of 0 to 2, the 255 corner with release at clock 264, and overruns forced by short cycles. For every vector, the bench checks the pad state in every clock of the cycle against a model computed from the requirements.

// File: rtl/dual_pulse_pkg.sv
package dual_pulse_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_WAITLOW = 2'd1,
    PH_DRIVE   = 2'd2
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic dropOut;
    logic raiseOk;
    logic relPins;
  } strobe_t;

  // status from datapath to control
  typedef struct packed {
    logic fall;
    logic lowHit;
    logic relHit;
  } status_t;

endpackage

// File: rtl/dual_pulse_dp.sv
module dual_pulse_dp
  import dual_pulse_pkg::*;
#(
  parameter int TW          = 16,
  parameter int DW          = 8,
  parameter int NCH         = 2,
  parameter int EARLY_OFF   = 2,
  parameter int RELEASE_DLY = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              senseIn,
  input  logic [NCH*DW-1:0] delayIn,
  input  strobe_t           stb,
  output status_t           stat,
  output logic [NCH-1:0]    padOut,
  output logic [NCH-1:0]    padOe,
  output logic [TW-1:0]     cycleLen
);

  localparam logic [TW-1:0] LOW_AT  = TW'(EARLY_OFF);
  localparam logic [TW-1:0] MIN_EFF = TW'(EARLY_OFF + 1);
  localparam logic [TW-1:0] REL_GAP = TW'(RELEASE_DLY);

  logic [TW-1:0] timer;
  logic [TW-1:0] capTime;
  logic [TW-1:0] prevCap;
  logic [TW-1:0] relAt;
  logic [TW-1:0] elapsed;
  logic [TW-1:0] maxNext;
  logic          havePrev;
  logic          senseLast;

  // free-running timebase
  always_ff @(posedge clk) begin
    if (!rstN) timer <= '0;
    else       timer <= timer + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) senseLast <= 1'b0;
    else       senseLast <= senseIn;
  end

  // largest requested delay, floored so a low phase always precedes a rise
  always_comb begin
    maxNext = MIN_EFF;
    for (int i = 0; i < NCH; i++) begin
      if (TW'(delayIn[i*DW +: DW]) > maxNext) maxNext = TW'(delayIn[i*DW +: DW]);
    end
  end

  // stamp, release point and period measurement
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capTime  <= '0;
      prevCap  <= '0;
      relAt    <= '0;
      havePrev <= 1'b0;
      cycleLen <= '0;
    end else if (stb.capture) begin
      capTime  <= timer;
      relAt    <= maxNext + REL_GAP;
      prevCap  <= timer;
      havePrev <= 1'b1;
      if (havePrev) cycleLen <= timer - prevCap;
    end
  end

  assign elapsed     = timer - capTime;
  assign stat.fall   = senseLast & ~senseIn;
  assign stat.lowHit = (elapsed == LOW_AT);
  assign stat.relHit = (elapsed >= relAt);

  for (genvar g = 0; g < NCH; g++) begin : gChan
    logic [DW-1:0] dlyLat;
    logic          outQ;
    logic          oeQ;
    logic          reach;

    assign reach = (elapsed >= TW'(dlyLat));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        dlyLat <= '0;
        outQ   <= 1'b1;
        oeQ    <= 1'b0;
      end else begin
        if (stb.capture) dlyLat <= delayIn[g*DW +: DW];
        if (stb.relPins) begin
          oeQ  <= 1'b0;
          outQ <= 1'b1;
        end else if (stb.dropOut) begin
          oeQ  <= 1'b1;
          outQ <= 1'b0;
        end else if (stb.raiseOk && reach) begin
          outQ <= 1'b1;
        end
      end
    end

    assign padOut[g] = outQ;
    assign padOe[g]  = oeQ;
  end

endmodule

// File: rtl/dual_pulse_ctrl.sv
module dual_pulse_ctrl
  import dual_pulse_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  status_t stat,
  output strobe_t stb,
  output logic    overrun
);

  phase_e phase;
  phase_e phaseNext;

  always_comb begin
    stb       = '0;
    phaseNext = phase;
    if (stat.fall) begin
      stb.capture = 1'b1;
      stb.relPins = (phase != PH_IDLE);
      phaseNext   = PH_WAITLOW;
    end else begin
      unique case (phase)
        PH_WAITLOW: begin
          if (stat.lowHit) begin
            stb.dropOut = 1'b1;
            phaseNext   = PH_DRIVE;
          end
        end
        PH_DRIVE: begin
          stb.raiseOk = 1'b1;
          if (stat.relHit) begin
            stb.relPins = 1'b1;
            phaseNext   = PH_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      overrun <= 1'b0;
    end else begin
      phase <= phaseNext;
      if (stat.fall) overrun <= (phase != PH_IDLE);
    end
  end

endmodule

// File: rtl/dual_pulse_timer.sv
module dual_pulse_timer
  import dual_pulse_pkg::*;
#(
  parameter int TW          = 16,
  parameter int DW          = 8,
  parameter int NCH         = 2,
  parameter int EARLY_OFF   = 2,
  parameter int RELEASE_DLY = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              senseIn,
  input  logic [NCH*DW-1:0] delayIn,
  output logic [NCH-1:0]    padOut,
  output logic [NCH-1:0]    padOe,
  output logic [TW-1:0]     cycleLen,
  output logic              overrun
);

  strobe_t stb;
  status_t stat;

  dual_pulse_dp #(
    .TW(TW), .DW(DW), .NCH(NCH),
    .EARLY_OFF(EARLY_OFF), .RELEASE_DLY(RELEASE_DLY)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .senseIn  (senseIn),
    .delayIn  (delayIn),
    .stb      (stb),
    .stat     (stat),
    .padOut   (padOut),
    .padOe    (padOe),
    .cycleLen (cycleLen)
  );

  dual_pulse_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .stat    (stat),
    .stb     (stb),
    .overrun (overrun)
  );

endmodule

// File: rtl/dual_pulse_checker.sv
module dual_pulse_checker #(
  parameter int TW  = 16,
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rstN,
  input logic           senseIn,
  input logic [NCH-1:0] padOut,
  input logic [NCH-1:0] padOe,
  input logic [TW-1:0]  cycleLen,
  input logic           overrun
);

  AST_RELEASED_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (padOe == '0) |-> (padOut == '1)); // R2

  AST_ENABLE_STARTS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(padOe[0]) |-> (padOut == '0)); // R3

  AST_PADS_TOGETHER: assert property (@(posedge clk) disable iff (!rstN)
    (padOe == '0) || (padOe == '1)); // R6

  for (genvar g = 0; g < NCH; g++) begin : gMono
    AST_HIGH_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      (padOe[g] && $past(padOe[g]) && $past(padOut[g])) |-> padOut[g]); // R4
  end

  AST_PERIOD_ON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cycleLen) |-> ($past(senseIn, 2) && !$past(senseIn, 1))); // R8

  AST_OVERRUN_ON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(overrun) |-> ($past(senseIn, 2) && !$past(senseIn, 1))); // R10

endmodule

bind dual_pulse_timer dual_pulse_checker #(.TW(TW), .NCH(NCH)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .senseIn  (senseIn),
  .padOut   (padOut),
  .padOe    (padOe),
  .cycleLen (cycleLen),
  .overrun  (overrun)
);

// File: tb/sim_dual_pulse_timer.sv
module sim_dual_pulse_timer;

  localparam int EARLY = 2;
  localparam int RELD  = 8;
  localparam int NV    = 6;
  // {delay ch0, delay ch1, cycle period}
  localparam int VEC [NV][3] = '{
    '{10, 20, 512}, '{0, 1, 400}, '{255, 3, 600},
    '{254, 254, 520}, '{2, 3, 300}, '{100, 50, 700}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        senseIn = 1'b1;
  logic [15:0] delayIn = '0;
  logic [1:0]  padOut;
  logic [1:0]  padOe;
  logic [15:0] cycleLen;
  logic        overrun;

  int checks = 0;
  int fails  = 0;
  int prevP  = 0;
  int prevRel = 0;

  always #5 clk = ~clk;

  dual_pulse_timer u0 (
    .clk(clk), .rstN(rstN), .senseIn(senseIn), .delayIn(delayIn),
    .padOut(padOut), .padOe(padOe), .cycleLen(cycleLen), .overrun(overrun)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // one measurement cycle: falling edge, then P clocks checked one by one
  task automatic runCycle(input int dA, input int dB, input int per,
                          input int chgAt, input int lateA, input int lateB);
    int hiA, hiB, rel, expOe, expOut;
    hiA = imax(dA, EARLY + 1) + 1;             // R4 R5
    hiB = imax(dB, EARLY + 1) + 1;
    rel = imax(imax(dA, dB), EARLY + 1) + RELD + 1; // R6
    delayIn = {8'(dB), 8'(dA)};
    senseIn = 1'b0;                             // R1 falling edge
    for (int k = 1; k <= per; k++) begin
      @(negedge clk);
      if (k == chgAt) delayIn = {8'(lateB), 8'(lateA)}; // R9
      if (k == per / 2) senseIn = 1'b1;         // R1 rising edge ignored
      if (k == 1) begin
        chk("R8 cycleLen", int'(cycleLen), prevP);
        chk("R10 overrun", int'(overrun), (prevP != 0 && prevRel > prevP) ? 1 : 0);
      end
      expOe  = (k >= EARLY + 1 && k < rel) ? 3 : 0; // R3 R6
      expOut = (expOe == 0) ? 3 : (((k >= hiB) ? 2 : 0) | ((k >= hiA) ? 1 : 0));
      chk("R3/R6 padOe", int'(padOe), expOe);
      chk("R4/R5 padOut", int'(padOut), expOut);
    end
    prevP   = per;
    prevRel = rel;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2 reset state
    chk("R2 padOe reset", int'(padOe), 0);
    chk("R2 padOut reset", int'(padOut), 3);
    chk("R2 cycleLen reset", int'(cycleLen), 0);
    chk("R2 overrun reset", int'(overrun), 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 padOe idle", int'(padOe), 0);
    chk("R2 padOut idle", int'(padOut), 3);

    // table walk: R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      runCycle(VEC[v][0], VEC[v][1], VEC[v][2], 0, 0, 0);
    end

    // R9: delay change mid-cycle must not move this cycle's edges
    runCycle(30, 40, 300, 5, 120, 130);
    // next cycle uses the values written late
    runCycle(120, 130, 300, 0, 0, 0);

    // R7: 255 on both channels, released by 264
    runCycle(255, 255, 512, 0, 0, 0);

    // R10: short cycle forces an edge before release
    runCycle(200, 200, 100, 0, 0, 0);
    runCycle(5, 5, 50, 0, 0, 0);   // sees overrun = 1, pads released at k=1
    runCycle(5, 5, 50, 0, 0, 0);   // sees overrun cleared

    // closing edge to check the last period and the cleared overrun
    senseIn = 1'b0;
    @(negedge clk);
    chk("R8 cycleLen final", int'(cycleLen), 50);
    chk("R10 overrun final", int'(overrun), 0);
    chk("R1 padOe after edge", int'(padOe), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule